// File: doc/BRIEF.md
# Sample Statistics Monitor

This block watches a stream of 22-bit two's complement samples. Each sample comes with a valid strobe and two flags that mark a positive or a negative overflow upstream. The block keeps a stored value and a saturating event counter. In the two capture modes the stored value tracks the running maximum or minimum of the stream. In the two counting modes the stored value is a fixed threshold, and the counter records how many samples went above or below it. Two sticky history bits, stored beside the value, record whether either kind of overflow has ever been seen.

The host never reaches the live value or the live counter directly. Each one has a buffer register. A host write to a dedicated copy address moves the buffer into the live register. A host read of that copy address takes a snapshot of the live register into its buffer, which the host can then read at leisure. Copies may happen at any time, including while samples are flowing. The samples themselves are not changed or forwarded by this block.

Top module: `statmon_unit`

## Requirements
- R1: The host writes the mode at address 0 in bits [1:0]: 00 is minimum capture, 01 is maximum capture, 10 is undershoot count, 11 is overshoot count. Reading address 0 returns the mode. In the two counting modes the stored value never changes because of a sample.
- R2: In overshoot mode the counter advances only for a sample strictly greater than the stored threshold (signed comparison). In undershoot mode it advances only for a sample strictly less than it. The effect is visible one clock after the sample is presented.
- R3: In overshoot mode a positive-overflow sample always counts and a negative-overflow sample never counts, whatever its data bits. Undershoot mode is the mirror image: a negative overflow always counts and a positive overflow never does.
- R4: In maximum capture mode a sample greater than the stored value replaces it and advances the counter. In minimum capture mode a smaller sample does the same. A sample that carries either overflow flag never replaces the value and does not count in these modes.
- R5: The 22-bit counter stops at 0x3FFFFF and does not wrap.
- R6: The counter advances by at most one per clock. A cycle with the sample valid strobe low changes neither the counter nor the stored value.
- R7: The host sees the stored register as a 24-bit word: bits [21:0] are the value, bit 22 is set by any positive-overflow sample and bit 23 by any negative-overflow sample. Both bits stay set in every mode.
- R8: A host write to address 3 loads buffer bits [21:0] (address 1) into the stored value and clears both history bits. When it falls in the same cycle as a sample, the host load wins for the value and for the history bits.
- R9: A host read of address 3 copies the 24-bit stored register into the buffer at address 1. A host read of address 4 copies the counter into its buffer at address 2. A host write to address 4 loads the counter from that buffer. Reads of addresses 3 and 4 return zero, and a buffer keeps its snapshot until the next copy or host write.
- R10: After reset the mode is minimum capture, and the stored value, history bits, counter and both buffers are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_data | input | DW (22) | Signed sample value |
| smp_ovf_pos | input | 1 | Sample has overflowed in the positive direction |
| smp_ovf_neg | input | 1 | Sample has overflowed in the negative direction |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (triggers a snapshot at copy addresses) |
| host_addr | input | AW (3) | Host register address |
| host_wdata | input | DW+2 (24) | Host write data |
| host_rdata | output | DW+2 (24) | Host read data, combinational from the address |

## Verification
The bench builds the block with its default values: a 22-bit sample and a 22-bit saturating counter. Counting all the way to the counter's limit would take millions of samples. Instead, the saturation boundary is reached by loading a value just below the limit through the counter buffer and its copy address, and then sending a few overshoot samples. Random phases switch the mode, draw samples near the threshold with occasional overflow flags, and compare snapshots against a bench model. Directed cases cover equal samples, overflowed samples in every mode, a host load colliding with a sample, and snapshots that must stay frozen while the live state moves on.

// File: rtl/statmon_pkg.sv
package statmon_pkg;
   // bit 1 selects the counting modes (fixed threshold), bit 0 selects the upward direction
   typedef enum logic [1:0] {
      MD_MIN   = 2'b00,
      MD_MAX   = 2'b01,
      MD_UNDER = 2'b10,
      MD_OVER  = 2'b11
   } stm_mode_e;
endpackage

// File: rtl/stm_compare.sv
module stm_compare #(
   parameter int DW = 22
) (
   input  logic [DW-1:0] smp_data,
   input  logic [DW-1:0] ref_val,
   input  logic          ovf_pos,
   input  logic          ovf_neg,
   output logic          above,
   output logic          below
);
   logic gt_raw, lt_raw;

   always_comb begin
      gt_raw = $signed(smp_data) > $signed(ref_val);
      lt_raw = $signed(smp_data) < $signed(ref_val);
      // an overflow decides the direction, whatever the data bits say
      above  = ovf_pos | (~ovf_neg & gt_raw);
      below  = ovf_neg | (~ovf_pos & lt_raw);
   end
endmodule

// File: rtl/stm_host_port.sv
module stm_host_port import statmon_pkg::*; #(
   parameter int DW        = 22,
   parameter int CW        = 22,
   parameter int AW        = 3,
   parameter int A_MODE    = 0,
   parameter int A_EXT_BUF = 1,
   parameter int A_CNT_BUF = 2,
   parameter int A_EXT_CPY = 3,
   parameter int A_CNT_CPY = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [AW-1:0]    host_addr,
   input  logic [DW+1:0]    host_wdata,
   input  logic [DW+1:0]    ext_live,
   input  logic [CW-1:0]    cnt_live,
   output stm_mode_e        mode,
   output logic [DW+1:0]    ext_buf,
   output logic [CW-1:0]    cnt_buf,
   output logic             ext_load,
   output logic             cnt_load,
   output logic [DW+1:0]    host_rdata
);
   localparam int HW = DW + 2;

   logic sel_mode, sel_ebuf, sel_cbuf, sel_ecpy, sel_ccpy;
   logic ext_snap, cnt_snap;

   always_comb begin
      sel_mode = host_addr == AW'(A_MODE);
      sel_ebuf = host_addr == AW'(A_EXT_BUF);
      sel_cbuf = host_addr == AW'(A_CNT_BUF);
      sel_ecpy = host_addr == AW'(A_EXT_CPY);
      sel_ccpy = host_addr == AW'(A_CNT_CPY);
      ext_load = host_wr & sel_ecpy;
      cnt_load = host_wr & sel_ccpy;
      ext_snap = host_rd & ~host_wr & sel_ecpy;
      cnt_snap = host_rd & ~host_wr & sel_ccpy;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= MD_MIN;
         ext_buf <= '0;
         cnt_buf <= '0;
      end else begin
         if (host_wr && sel_mode)
            mode <= stm_mode_e'(host_wdata[1:0]);
         if (host_wr && sel_ebuf)
            ext_buf <= host_wdata;
         else if (ext_snap)
            ext_buf <= ext_live;
         if (host_wr && sel_cbuf)
            cnt_buf <= host_wdata[CW-1:0];
         else if (cnt_snap)
            cnt_buf <= cnt_live;
      end
   end

   always_comb begin
      host_rdata = '0;
      if (sel_mode)
         host_rdata = HW'(mode);
      else if (sel_ebuf)
         host_rdata = ext_buf;
      else if (sel_cbuf)
         host_rdata = HW'(cnt_buf);
   end
endmodule

// File: rtl/stm_extreme_reg.sv
module stm_extreme_reg import statmon_pkg::*; #(
   parameter int DW = 22
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_data,
   input  logic          ovf_pos,
   input  logic          ovf_neg,
   input  stm_mode_e     mode,
   input  logic          above,
   input  logic          below,
   input  logic          host_load,
   input  logic [DW-1:0] host_val,
   output logic [DW-1:0] thr,
   output logic [1:0]    hist,
   output logic          hit
);
   logic clean;
   logic capture;

   always_comb begin
      clean = ~ovf_pos & ~ovf_neg;
      unique case (mode)
         MD_MIN:   hit = smp_valid & clean & below;
         MD_MAX:   hit = smp_valid & clean & above;
         MD_UNDER: hit = smp_valid & below;
         MD_OVER:  hit = smp_valid & above;
         default:  hit = 1'b0;
      endcase
      capture = hit & ~mode[1];
   end

   // hist[0] records positive overflows, hist[1] negative overflows
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr  <= '0;
         hist <= '0;
      end else if (host_load) begin
         thr  <= host_val;
         hist <= '0;
      end else begin
         if (smp_valid)
            hist <= hist | {ovf_neg, ovf_pos};
         if (capture)
            thr <= smp_data;
      end
   end
endmodule

// File: rtl/stm_event_ctr.sv
module stm_event_ctr #(
   parameter int CW       = 22,
   parameter bit SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] CNT_TOP = '1;

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (load)
               cnt <= load_val;
            else if (inc && cnt != CNT_TOP)
               cnt <= cnt + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (load)
               cnt <= load_val;
            else if (inc)
               cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/statmon_unit.sv
module statmon_unit import statmon_pkg::*; #(
   parameter int DW        = 22,
   parameter int CW        = 22,
   parameter int AW        = 3,
   parameter bit SATURATE  = 1'b1,
   parameter int A_MODE    = 0,
   parameter int A_EXT_BUF = 1,
   parameter int A_CNT_BUF = 2,
   parameter int A_EXT_CPY = 3,
   parameter int A_CNT_CPY = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [DW-1:0]    smp_data,
   input  logic             smp_ovf_pos,
   input  logic             smp_ovf_neg,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic [AW-1:0]    host_addr,
   input  logic [DW+1:0]    host_wdata,
   output logic [DW+1:0]    host_rdata
);
   localparam int HW = DW + 2;

   generate
      if (DW < 2) begin : g_bad_dw
         $error("statmon_unit: DW must be at least 2");
      end
      if (CW < 1 || CW > HW) begin : g_bad_cw
         $error("statmon_unit: CW must lie between 1 and DW+2");
      end
      if ((1 << AW) <= A_CNT_CPY || (1 << AW) <= A_EXT_CPY) begin : g_bad_aw
         $error("statmon_unit: AW too narrow for the address map");
      end
   endgenerate

   stm_mode_e     mode;
   logic [HW-1:0] ext_buf;
   logic [CW-1:0] cnt_buf;
   logic          ext_load, cnt_load;
   logic [DW-1:0] thr;
   logic [1:0]    hist;
   logic [CW-1:0] cnt;
   logic          above, below, hit;
   logic [HW-1:0] ext_live;

   assign ext_live = {hist, thr};

   stm_host_port #(
      .DW(DW), .CW(CW), .AW(AW),
      .A_MODE(A_MODE), .A_EXT_BUF(A_EXT_BUF), .A_CNT_BUF(A_CNT_BUF),
      .A_EXT_CPY(A_EXT_CPY), .A_CNT_CPY(A_CNT_CPY)
   ) u_host (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .ext_live   (ext_live),
      .cnt_live   (cnt),
      .mode       (mode),
      .ext_buf    (ext_buf),
      .cnt_buf    (cnt_buf),
      .ext_load   (ext_load),
      .cnt_load   (cnt_load),
      .host_rdata (host_rdata)
   );

   stm_compare #(.DW(DW)) u_cmp (
      .smp_data (smp_data),
      .ref_val  (thr),
      .ovf_pos  (smp_ovf_pos),
      .ovf_neg  (smp_ovf_neg),
      .above    (above),
      .below    (below)
   );

   stm_extreme_reg #(.DW(DW)) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .ovf_pos   (smp_ovf_pos),
      .ovf_neg   (smp_ovf_neg),
      .mode      (mode),
      .above     (above),
      .below     (below),
      .host_load (ext_load),
      .host_val  (ext_buf[DW-1:0]),
      .thr       (thr),
      .hist      (hist),
      .hit       (hit)
   );

   stm_event_ctr #(.CW(CW), .SATURATE(SATURATE)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (hit),
      .load     (cnt_load),
      .load_val (cnt_buf),
      .cnt      (cnt)
   );
endmodule

// File: rtl/statmon_unit_chk.sv
module statmon_unit_chk #(
   parameter int DW       = 22,
   parameter int CW       = 22,
   parameter bit SATURATE = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_valid,
   input logic          smp_ovf_pos,
   input logic          smp_ovf_neg,
   input logic [1:0]    mode,
   input logic [DW-1:0] thr,
   input logic [1:0]    hist,
   input logic [CW-1:0] cnt,
   input logic          ext_load,
   input logic          cnt_load,
   input logic [DW+1:0] ext_buf,
   input logic [CW-1:0] cnt_buf
);
   localparam logic [CW-1:0] TOP = '1;

   assert_count_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && !ext_load) |=> $stable(thr));

   assert_ovf_no_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && (smp_ovf_pos || smp_ovf_neg) && !mode[1] && !ext_load) |=> $stable(thr));

   generate
      if (SATURATE) begin : g_sat_chk
         assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == TOP && !cnt_load) |=> cnt == TOP);
      end
   endgenerate

   assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_load |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1'b1)));

   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !cnt_load) |=> $stable(cnt));

   assert_hist_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_ovf_pos && !ext_load) |=> hist[0]);

   assert_hist_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_ovf_neg && !ext_load) |=> hist[1]);

   assert_host_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ext_load |=> (hist == 2'b00 && thr == $past(ext_buf[DW-1:0])));

   assert_cnt_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> cnt == $past(cnt_buf));
endmodule

bind statmon_unit statmon_unit_chk #(.DW(DW), .CW(CW), .SATURATE(SATURATE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid   (smp_valid),
   .smp_ovf_pos (smp_ovf_pos),
   .smp_ovf_neg (smp_ovf_neg),
   .mode        (mode),
   .thr         (thr),
   .hist        (hist),
   .cnt         (cnt),
   .ext_load    (ext_load),
   .cnt_load    (cnt_load),
   .ext_buf     (ext_buf),
   .cnt_buf     (cnt_buf)
);

// File: tb/statmon_unit_bench.sv
module statmon_unit_bench;
   localparam int DW = 22;
   localparam int CW = 22;
   localparam int AW = 3;
   localparam int HW = DW + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic smp_ovf_pos = 1'b0;
   logic smp_ovf_neg = 1'b0;
   logic host_wr = 1'b0;
   logic host_rd = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [HW-1:0] host_wdata = '0;
   logic [HW-1:0] host_rdata;

   always #2 clk = ~clk;

   statmon_unit u_statmon_unit (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_ovf_pos(smp_ovf_pos), .smp_ovf_neg(smp_ovf_neg),
      .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic signed [DW-1:0] m_thr = '0;
   logic m_hp = 1'b0, m_hn = 1'b0;
   logic [CW-1:0] m_cnt = '0;
   logic [1:0] m_mode = 2'b00;

   task automatic check(string req, logic [HW-1:0] act, logic [HW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   function automatic logic [CW-1:0] bump(logic [CW-1:0] c);
      return (c == '1) ? c : c + 1'b1;
   endfunction

   // model of one valid sample
   task automatic model_sample(logic signed [DW-1:0] d, logic p, logic n);
      logic ab, bl, cl;
      ab = p | (!n && d > m_thr);
      bl = n | (!p && d < m_thr);
      cl = !p && !n;
      case (m_mode)
         2'b00: if (bl && cl) begin m_thr = d; m_cnt = bump(m_cnt); end
         2'b01: if (ab && cl) begin m_thr = d; m_cnt = bump(m_cnt); end
         2'b10: if (bl) m_cnt = bump(m_cnt);
         default: if (ab) m_cnt = bump(m_cnt);
      endcase
      if (p) m_hp = 1'b1;
      if (n) m_hn = 1'b1;
   endtask

   task automatic hwrite(int a, logic [HW-1:0] v);
      host_wr = 1'b1; host_addr = AW'(a); host_wdata = v;
      @(posedge clk); #1;
      host_wr = 1'b0;
   endtask

   task automatic snap(int cpy, int bufa, output logic [HW-1:0] v);
      host_rd = 1'b1; host_addr = AW'(cpy);
      @(posedge clk); #1;
      host_rd = 1'b0; host_addr = AW'(bufa);
      #1 v = host_rdata;
   endtask

   task automatic send(logic signed [DW-1:0] d, logic p, logic n);
      smp_valid = 1'b1; smp_data = d; smp_ovf_pos = p; smp_ovf_neg = n;
      model_sample(d, p, n);
      @(posedge clk); #1;
      smp_valid = 1'b0; smp_ovf_pos = 1'b0; smp_ovf_neg = 1'b0;
   endtask

   task automatic check_state(string req);
      logic [HW-1:0] v;
      snap(3, 1, v);
      check({req, " stored"}, v, {m_hn, m_hp, m_thr});
      snap(4, 2, v);
      check({req, " count"}, v, HW'(m_cnt));
   endtask

   task automatic set_mode(logic [1:0] m);
      hwrite(0, HW'(m)); m_mode = m;
   endtask

   task automatic load_ext(logic signed [DW-1:0] v);
      hwrite(1, HW'(v)); hwrite(3, '0);
      m_thr = v; m_hp = 1'b0; m_hn = 1'b0;
   endtask

   task automatic load_cnt(logic [CW-1:0] v);
      hwrite(2, HW'(v)); hwrite(4, '0);
      m_cnt = v;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [HW-1:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R10 reset state
      host_addr = 3'd0; #1 check("R10 mode after reset", host_rdata, '0);
      host_addr = 3'd1; #1 check("R10 value buffer", host_rdata, '0);
      host_addr = 3'd2; #1 check("R10 count buffer", host_rdata, '0);
      check_state("R10");
      host_addr = 3'd3; #1 check("R9 copy address reads zero", host_rdata, '0);

      // R4 min capture, equal does not replace, overflow never replaces, R7 history
      load_ext(22'sd100); load_cnt('0);
      send(22'sd50, 0, 0); send(22'sd50, 0, 0); send(22'sd60, 0, 0);
      send(-22'sd200, 0, 1);
      check_state("R4 min capture");
      check("R7 neg history", {m_hn, m_hp}, 2'b10);

      // R4 max capture
      set_mode(2'b01);
      host_addr = 3'd0; #1 check("R1 mode readback", host_rdata, 24'h1);
      load_ext(-22'sd5); load_cnt('0);
      send(22'sd10, 0, 0); send(22'sd3, 0, 0); send(22'sd20, 0, 0);
      send(22'sd1000, 1, 0);
      check_state("R4 max capture");

      // R2 R3 overshoot count, R1 threshold frozen
      set_mode(2'b11);
      load_ext(22'sd0); load_cnt('0);
      send(22'sd0, 0, 0); send(22'sd1, 0, 0); send(-22'sd7, 1, 0); send(22'sd100, 0, 1);
      check_state("R2 R3 overshoot");
      check("R3 overshoot count value", HW'(m_cnt), 24'd2);

      // R2 R3 undershoot
      set_mode(2'b10);
      load_ext(22'sd10); load_cnt('0);
      send(22'sd10, 0, 0); send(22'sd9, 0, 0); send(22'sd50, 0, 1); send(-22'sd50, 1, 0);
      check_state("R2 R3 undershoot");
      check("R1 threshold unchanged", HW'(m_thr), 24'd10);

      // R5 saturation
      set_mode(2'b11);
      load_ext(22'sd0); load_cnt(22'h3FFFFE);
      send(22'sd5, 0, 0); send(22'sd5, 0, 0); send(22'sd5, 0, 0);
      check_state("R5 saturation");
      check("R5 at limit", HW'(m_cnt), 24'h3FFFFF);

      // R8 host load wins over a same-cycle sample
      set_mode(2'b01);
      load_ext(22'sd0); load_cnt('0);
      hwrite(1, 24'd77);
      host_wr = 1'b1; host_addr = 3'd3; host_wdata = '0;
      smp_valid = 1'b1; smp_data = 22'sd500; smp_ovf_pos = 1'b0; smp_ovf_neg = 1'b0;
      model_sample(22'sd500, 0, 0);
      m_thr = 22'sd77; m_hp = 1'b0; m_hn = 1'b0;
      @(posedge clk); #1;
      host_wr = 1'b0; smp_valid = 1'b0;
      check_state("R8 collision");
      host_wr = 1'b1; host_addr = 3'd3;
      smp_valid = 1'b1; smp_data = 22'sd9; smp_ovf_pos = 1'b1;
      model_sample(22'sd9, 1, 0);
      m_thr = 22'sd77; m_hp = 1'b0; m_hn = 1'b0;
      @(posedge clk); #1;
      host_wr = 1'b0; smp_valid = 1'b0; smp_ovf_pos = 1'b0;
      check_state("R8 collision clears history");

      // R9 snapshot frozen while live state moves
      snap(3, 1, v);
      send(22'sd300, 0, 0);
      host_addr = 3'd1; #1 check("R9 buffer holds snapshot", host_rdata, {2'b00, 22'sd77});
      check_state("R9 after move");

      // R6 invalid samples ignored
      smp_valid = 1'b0; smp_data = 22'h1FFFFF; smp_ovf_neg = 1'b1;
      repeat (4) @(posedge clk);
      #1 smp_ovf_neg = 1'b0;
      check_state("R6 valid low ignored");

      // random phases
      for (int i = 0; i < 3000; i++) begin
         logic signed [DW-1:0] d;
         logic p, n;
         int r;
         if (i % 250 == 0) begin
            set_mode(2'($urandom));
            load_ext(DW'($signed($urandom_range(0, 200)) - 100));
         end
         r = $urandom_range(0, 19);
         d = (r == 0) ? DW'($urandom) : DW'($signed($urandom_range(0, 400)) - 200);
         p = (r == 1);
         n = (r == 2);
         if ($urandom_range(0, 7) == 0) begin
            smp_valid = 1'b0; smp_data = d;
            @(posedge clk); #1;
         end else
            send(d, p, n);
         if (i % 60 == 59) check_state("R2 R4 R7 random");
      end
      check_state("R6 random end");
      finish_run();
   end
endmodule